// File: doc/BRIEF.md
# Clock Policy Mask Controller

This block is the register file of a clock control unit that decides which clocks run under each power policy. It keeps one enable mask for every policy. Each mask has one bit per clock, and the same bit position in every mask belongs to the same clock. A policy-select input chooses the active policy. The block drives a registered per-clock enable vector taken from that policy's mask.

The masks can only be edited while the policy engine is halted. Software halts the engine through a software-update enable bit, edits the masks, then restarts the engine by writing the GO bit together with one of two restart-mode bits. The enable vector is frozen while the engine is halted and is reloaded at restart. Changes to the masks therefore never reach the clocks part-way through an edit.

Every register except the access register is guarded by a write gate. The gate opens when a 24-bit key with bit 0 set is written to the access register. Any other value written there closes the gate. The bus is a plain single-cycle register port made of a word address, write data and a write strobe. Read data appears one cycle after the address is presented.

Top module: `cpm_ctrl`

Register words (the word index is the address): 0 = access (key in bits 31:8, write enable in bit 0), 1 = update (bit 0 halts the engine; reads 1 while halted), 2 = control (bit 0 GO, bit 1 restart mode A, bit 2 restart mode B), 3 = status (bit 0 sticky error, write 1 to clear), 4 + p = mask of policy p.

## Requirements
- R1: After reset the engine runs, the write gate is closed, policy 0 is active, every mask bit is 1, the enable vector is all ones, and the error flag is 0.
- R2: A write to word 0 with the key in bits 31:8 and bit 0 set opens the gate. Any other value written there closes it. Word 0 reads back the gate state in bit 0 and zero in every other bit.
- R3: While the gate is closed, writes to words 1 to 7 change nothing: the engine state, the masks and the error flag all keep their values.
- R4: With the gate open, writing 1 to bit 0 of word 1 halts the engine. Bit 0 of word 1 reads 1 while halted and 0 while running.
- R5: With the gate open and the engine halted, a write to word 4+p replaces the mask of policy p and does not set the error flag. The new mask reads back from the same word.
- R6: A mask write with the gate open while the engine runs is dropped and sets the sticky error flag (word 3 bit 0). The flag stays set until a 1 is written to word 3 bit 0.
- R7: With the gate open, a control write with bit 0 set and bit 1 or bit 2 set restarts the engine. A control write with bit 0 set and neither mode bit set is ignored. Bits 1 and 2 of word 2 read back the mode of the last restart.
- R8: The GO bit (word 2 bit 0) reads 1 only in the cycle just after the restart write and reads 0 from the next cycle on.
- R9: While halted, the enable vector keeps its value, whatever the masks become. On the restart edge it loads the mask of the policy last sampled while the engine ran.
- R10: While the engine runs, the policy-select input is sampled every cycle and the enable vector shows that policy's mask one cycle later. While halted, the select input is ignored.
- R11: Read data is registered: the word addressed in one cycle appears on the read bus after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Registered read data |
| pol_sel | input | 2 | Requested active policy |
| clk_en | output | 32 | Per-clock policy enable vector |

## Verification
The mask path is tried with four distinct patterns: a single nibble, an alternating pattern with a low bit, only the top bit, and all zeros. Each policy holds a different one, so reading the wrong policy or swapping two policies shows up as a wrong word. The select input is changed while the engine runs and again while it is halted, which separates live tracking from the frozen hold. Mask writes are tried with the gate closed, with the gate open while the engine runs, and with the gate open while halted, and each case has its own expected effect on the masks and the error flag. Restarts use each mode bit in turn, plus one GO write with no mode bit, so the one-cycle GO pulse and the mode readback are each checked.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned KEY_W     = 24;
  // word indices of the register port
  localparam int unsigned REG_ACCESS = 0;
  localparam int unsigned REG_UPDATE = 1;
  localparam int unsigned REG_CTRL   = 2;
  localparam int unsigned REG_STAT   = 3;
  localparam int unsigned REG_MASK0  = 4;
  // bit positions inside those words
  localparam int unsigned BIT_WEN   = 0;
  localparam int unsigned BIT_HALT  = 0;
  localparam int unsigned BIT_GO    = 0;
  localparam int unsigned BIT_MODEA = 1;
  localparam int unsigned BIT_MODEB = 2;
  localparam int unsigned BIT_ERR   = 0;

  typedef struct packed {
    logic mode_b;
    logic mode_a;
  } restart_mode_t;
endpackage

// File: rtl/cpm_access_gate.sv
module cpm_access_gate #(
  parameter int unsigned KEY_W  = 24,
  parameter logic [KEY_W-1:0] PASSKEY = 24'h3CA596
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_wr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             en_bit_i,
  output logic             unlocked_o
);
  logic wen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q <= 1'b0;
    end else if (acc_wr_i) begin
      wen_q <= (key_i == PASSKEY) && en_bit_i;
    end
  end

  assign unlocked_o = wen_q;

  AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (acc_wr_i && (key_i != PASSKEY)) |=> !unlocked_o); // R2
  AST_NO_WR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !acc_wr_i |=> $stable(unlocked_o)); // R2
endmodule

// File: rtl/cpm_mask_bank.sv
module cpm_mask_bank #(
  parameter int unsigned NCLK = 32,
  parameter int unsigned NPOL = 4,
  localparam int unsigned PW  = (NPOL > 1) ? $clog2(NPOL) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [PW-1:0]   widx_i,
  input  logic [NCLK-1:0] wdata_i,
  input  logic            halted_i,
  input  logic [PW-1:0]   pidx_i,
  output logic [NCLK-1:0] pword_o,
  input  logic [PW-1:0]   ridx_i,
  output logic [NCLK-1:0] rword_o
);
  logic [NCLK-1:0] mem [NPOL];

  for (genvar p = 0; p < NPOL; p++) begin : g_pol
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[p] <= '1;
      end else if (we_i && (widx_i == PW'(p))) begin
        mem[p] <= wdata_i;
      end
    end
  end

  always_comb begin
    pword_o = '0;
    rword_o = '0;
    for (int p = 0; p < NPOL; p++) begin
      if (pidx_i == PW'(p)) pword_o = mem[p];
      if (ridx_i == PW'(p)) rword_o = mem[p];
    end
  end

  AST_MASK_ONLY_HALTED: assert property (@(posedge clk) disable iff (rst)
    we_i |-> halted_i); // R5
  AST_MASK_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (we_i && (ridx_i == widx_i)) |=> (rword_o == $past(wdata_i) || ridx_i != $past(widx_i))); // R5
endmodule

// File: rtl/cpm_engine.sv
module cpm_engine #(
  parameter int unsigned NCLK = 32,
  parameter int unsigned NPOL = 4,
  localparam int unsigned PW  = (NPOL > 1) ? $clog2(NPOL) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   unlocked_i,
  input  logic                   halt_wr_i,
  input  logic                   halt_bit_i,
  input  logic                   ctrl_wr_i,
  input  logic                   go_bit_i,
  input  cpm_pkg::restart_mode_t mode_i,
  input  logic                   stat_wr_i,
  input  logic                   err_clr_i,
  input  logic                   mask_try_i,
  input  logic [PW-1:0]          pol_sel_i,
  output logic [PW-1:0]          mask_idx_o,
  input  logic [NCLK-1:0]        mask_word_i,
  output logic                   running_o,
  output logic                   go_o,
  output cpm_pkg::restart_mode_t mode_o,
  output logic                   err_o,
  output logic [NCLK-1:0]        clk_en_o
);
  logic                   running_q;
  logic                   go_q;
  logic                   err_q;
  logic [PW-1:0]          act_pol_q;
  logic [NCLK-1:0]        en_q;
  cpm_pkg::restart_mode_t mode_q;
  logic                   go_fire;
  logic                   halt_fire;

  assign go_fire   = unlocked_i && ctrl_wr_i && go_bit_i && (mode_i.mode_a || mode_i.mode_b);
  assign halt_fire = unlocked_i && halt_wr_i && halt_bit_i;

  // at restart the frozen policy is loaded; while running the live request
  assign mask_idx_o = go_fire ? act_pol_q : pol_sel_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b1;
      go_q      <= 1'b0;
      mode_q    <= '0;
      act_pol_q <= '0;
      en_q      <= '1;
    end else begin
      go_q <= go_fire;
      if (go_fire) begin
        running_q <= 1'b1;
        mode_q    <= mode_i;
        en_q      <= mask_word_i;
      end else if (halt_fire) begin
        running_q <= 1'b0;
      end else if (running_q) begin
        act_pol_q <= pol_sel_i;
        en_q      <= mask_word_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (mask_try_i && running_q) begin
      err_q <= 1'b1;
    end else if (unlocked_i && stat_wr_i && err_clr_i) begin
      err_q <= 1'b0;
    end
  end

  assign running_o = running_q;
  assign go_o      = go_q;
  assign mode_o    = mode_q;
  assign err_o     = err_q;
  assign clk_en_o  = en_q;

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (!running_q && !(unlocked_i && ctrl_wr_i)) |=> $stable(clk_en_o)); // R9
  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    go_o |=> !go_o); // R8
  AST_GO_MEANS_RUN: assert property (@(posedge clk) disable iff (rst)
    go_o |-> running_o); // R7
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !unlocked_i |=> $stable(running_o)); // R3
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (mask_try_i && running_o) |=> err_o); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_o && !stat_wr_i) |=> err_o); // R6
endmodule

// File: rtl/cpm_ctrl.sv
module cpm_ctrl #(
  parameter int unsigned NCLK = 32,
  parameter int unsigned NPOL = 4,
  parameter logic [cpm_pkg::KEY_W-1:0] PASSKEY = 24'h3CA596,
  localparam int unsigned AW = $clog2(cpm_pkg::REG_MASK0 + NPOL),
  localparam int unsigned PW = (NPOL > 1) ? $clog2(NPOL) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [AW-1:0]              bus_addr,
  input  logic [cpm_pkg::DATA_W-1:0] bus_wdata,
  input  logic                       bus_we,
  output logic [cpm_pkg::DATA_W-1:0] bus_rdata,
  input  logic [PW-1:0]              pol_sel,
  output logic [NCLK-1:0]            clk_en
);
  import cpm_pkg::*;

  logic                 unlocked;
  logic                 running;
  logic                 go;
  logic                 err;
  restart_mode_t        mode;
  restart_mode_t        wr_mode;
  logic                 is_mask;
  logic [AW-1:0]        mask_off;
  logic [PW-1:0]        mask_idx;
  logic [PW-1:0]        eng_idx;
  logic [NCLK-1:0]      eng_word;
  logic [NCLK-1:0]      bus_word;
  logic                 mask_try;
  logic                 mask_we;
  logic [DATA_W-1:0]    rdata_q;

  assign is_mask  = (bus_addr >= AW'(REG_MASK0));
  assign mask_off = bus_addr - AW'(REG_MASK0);
  assign mask_idx = mask_off[PW-1:0];
  assign mask_try = bus_we && is_mask && unlocked;
  assign mask_we  = mask_try && !running;
  assign wr_mode  = '{mode_b: bus_wdata[BIT_MODEB], mode_a: bus_wdata[BIT_MODEA]};

  cpm_access_gate #(
    .KEY_W   (KEY_W),
    .PASSKEY (PASSKEY)
  ) u_gate (
    .clk        (clk),
    .rst        (rst),
    .acc_wr_i   (bus_we && (bus_addr == AW'(REG_ACCESS))),
    .key_i      (bus_wdata[DATA_W-1 -: KEY_W]),
    .en_bit_i   (bus_wdata[BIT_WEN]),
    .unlocked_o (unlocked)
  );

  cpm_mask_bank #(
    .NCLK (NCLK),
    .NPOL (NPOL)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .we_i     (mask_we),
    .widx_i   (mask_idx),
    .wdata_i  (bus_wdata[NCLK-1:0]),
    .halted_i (!running),
    .pidx_i   (eng_idx),
    .pword_o  (eng_word),
    .ridx_i   (mask_idx),
    .rword_o  (bus_word)
  );

  cpm_engine #(
    .NCLK (NCLK),
    .NPOL (NPOL)
  ) u_engine (
    .clk         (clk),
    .rst         (rst),
    .unlocked_i  (unlocked),
    .halt_wr_i   (bus_we && (bus_addr == AW'(REG_UPDATE))),
    .halt_bit_i  (bus_wdata[BIT_HALT]),
    .ctrl_wr_i   (bus_we && (bus_addr == AW'(REG_CTRL))),
    .go_bit_i    (bus_wdata[BIT_GO]),
    .mode_i      (wr_mode),
    .stat_wr_i   (bus_we && (bus_addr == AW'(REG_STAT))),
    .err_clr_i   (bus_wdata[BIT_ERR]),
    .mask_try_i  (mask_try),
    .pol_sel_i   (pol_sel),
    .mask_idx_o  (eng_idx),
    .mask_word_i (eng_word),
    .running_o   (running),
    .go_o        (go),
    .mode_o      (mode),
    .err_o       (err),
    .clk_en_o    (clk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (is_mask) begin
        rdata_q <= DATA_W'(bus_word);
      end else if (bus_addr == AW'(REG_ACCESS)) begin
        rdata_q[BIT_WEN] <= unlocked;
      end else if (bus_addr == AW'(REG_UPDATE)) begin
        rdata_q[BIT_HALT] <= !running;
      end else if (bus_addr == AW'(REG_CTRL)) begin
        rdata_q[BIT_GO]    <= go;
        rdata_q[BIT_MODEA] <= mode.mode_a;
        rdata_q[BIT_MODEB] <= mode.mode_b;
      end else begin
        rdata_q[BIT_ERR] <= err;
      end
    end
  end

  assign bus_rdata = rdata_q;

  AST_LOCKED_MASK_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && is_mask) |=> $stable(bus_word) || $changed(bus_addr)); // R3
  AST_ACCESS_READ_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == AW'(REG_ACCESS)) |=> (bus_rdata[DATA_W-1:1] == '0)); // R11
endmodule

// File: tb/cpm_ctrl_test.sv
module cpm_ctrl_test;
  localparam logic [23:0] KEY = 24'h3CA596;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  pol_sel = '0;
  logic [31:0] clk_en;

  int checks = 0;
  int fails  = 0;
  logic issue = 1'b0;
  logic done  = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [2:0]  addr;
    string       req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  cpm_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pol_sel(pol_sel), .clk_en(clk_en)
  );

  // monitor: the read data for an issued address is valid after this edge
  always @(posedge clk) begin
    if (issue) begin
      #2;
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL monitor: read with empty scoreboard");
      end else begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: word %0d read %h expected %h", it.req, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
    item_t it;
    it.exp = e; it.addr = a; it.req = req;
    sb.push_back(it);
    bus_addr = a; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic chk_en(input logic [31:0] e, input string req);
    checks++;
    if (clk_en !== e) begin
      fails++;
      $display("FAIL %s: clk_en %h expected %h", req, clk_en, e);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    // R1 reset state
    chk_en(32'hFFFF_FFFF, "R1");
    rd(3'd0, 32'h0, "R1");
    rd(3'd1, 32'h0, "R1");
    rd(3'd3, 32'h0, "R1");
    for (int p = 0; p < 4; p++) rd(3'(4 + p), 32'hFFFF_FFFF, "R1");
    // R3 locked writes are ignored
    wr(3'd1, 32'h1);
    rd(3'd1, 32'h0, "R3");
    wr(3'd4, 32'h0);
    rd(3'd4, 32'hFFFF_FFFF, "R3");
    rd(3'd3, 32'h0, "R3");
    // R2 key handling
    wr(3'd0, {24'h123456, 8'h01});
    rd(3'd0, 32'h0, "R2");
    wr(3'd0, {KEY, 8'h00});
    rd(3'd0, 32'h0, "R2");
    wr(3'd0, {KEY, 8'hFF});
    rd(3'd0, 32'h1, "R2");
    // R6 mask write while running is dropped and flagged
    wr(3'd5, 32'h0000_1234);
    rd(3'd5, 32'hFFFF_FFFF, "R6");
    rd(3'd3, 32'h1, "R6");
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h1, "R6");
    wr(3'd3, 32'h1);
    rd(3'd3, 32'h0, "R6");
    // R4 halt
    wr(3'd1, 32'h0);
    rd(3'd1, 32'h0, "R4");
    wr(3'd1, 32'h1);
    rd(3'd1, 32'h1, "R4");
    // R5 mask edits while halted
    wr(3'd4, 32'h0000_00F0);
    wr(3'd5, 32'hA5A5_0001);
    wr(3'd6, 32'h8000_0000);
    wr(3'd7, 32'h0000_0000);
    rd(3'd4, 32'h0000_00F0, "R5");
    rd(3'd5, 32'hA5A5_0001, "R5");
    rd(3'd6, 32'h8000_0000, "R5");
    rd(3'd7, 32'h0000_0000, "R5");
    rd(3'd3, 32'h0, "R5");
    // R9 frozen output, R10 select ignored while halted
    chk_en(32'hFFFF_FFFF, "R9");
    pol_sel = 2'd2;
    idle(); idle();
    chk_en(32'hFFFF_FFFF, "R10");
    // R7 GO without a mode bit is ignored
    wr(3'd2, 32'h1);
    rd(3'd1, 32'h1, "R7");
    chk_en(32'hFFFF_FFFF, "R7");
    // R7/R9 restart with mode A loads policy 0 (last sampled while running)
    wr(3'd2, 32'h3);
    chk_en(32'h0000_00F0, "R9");
    rd(3'd2, 32'h3, "R8");
    rd(3'd2, 32'h2, "R8");
    rd(3'd1, 32'h0, "R7");
    // R10 live tracking
    chk_en(32'h8000_0000, "R10");
    pol_sel = 2'd1;
    idle();
    chk_en(32'hA5A5_0001, "R10");
    pol_sel = 2'd3;
    idle();
    chk_en(32'h0000_0000, "R10");
    // R3 relock then halt attempt is ignored
    wr(3'd0, 32'h0);
    rd(3'd0, 32'h0, "R2");
    wr(3'd1, 32'h1);
    rd(3'd1, 32'h0, "R3");
    // R9 restart with mode B loads policy 3 sampled before halt
    wr(3'd0, {KEY, 8'h01});
    wr(3'd1, 32'h1);
    wr(3'd7, 32'hDEAD_BEEF);
    pol_sel = 2'd0;
    idle();
    chk_en(32'h0000_0000, "R9");
    wr(3'd2, 32'h5);
    chk_en(32'hDEAD_BEEF, "R9");
    rd(3'd2, 32'h5, "R8");
    rd(3'd2, 32'h4, "R7");
    chk_en(32'h0000_00F0, "R10");
    // R11 back-to-back reads return each word a cycle later
    rd(3'd7, 32'hDEAD_BEEF, "R11");
    rd(3'd4, 32'h0000_00F0, "R11");
    idle(); idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule